// File: doc/BRIEF.md
# Per-Stream Output Timing Advance Unit

This block moves each of sixteen serial output streams earlier in time by a programmable number of fast system-clock cycles. It sits just after a serializer that presents every bit a fixed six clocks ahead of its nominal slot. Each stream runs through its own six-stage delay line. The block picks one tap of that line, so the output can land anywhere from exact nominal alignment up to six cycles early.

Each stream has a small control register, written and read through a simple address/data port. A register holds a two-bit advance code. A global rate input decides how a code is turned into cycles. In the slow-rate mapping each code step is worth two cycles. In the fast-rate mapping each step is worth one cycle, and only the lower half of the streams carries data. A newly written code is held back until the next frame pulse, so a stream never changes timing in the middle of a frame.

Top module: `stream_advance_unit`

## Requirements
- R1: Each of the 16 streams has its own code register. A write to `reg_addr` stores `reg_wdata[1:0]` for that stream only. A read of that address returns the most recently written code on `reg_rdata[1:0]`, starting on the cycle after the write.
- R2: `reg_rdata[15:2]` always reads 0, whatever was written to those bit positions.
- R3: After reset every code reads 0 and every output is 0. With an active code of 0, an output equals its input delayed by 6 clocks (nominal alignment).
- R4: With `mode_fast`=0, active codes 1, 2 and 3 advance the output by 2, 4 and 6 cycles. The output is then the input delayed by 4, 2 and 0 clocks.
- R5: With `mode_fast`=1, active codes 1, 2 and 3 advance streams 0 to 7 by 1, 2 and 3 cycles. The output is then the input delayed by 5, 4 and 3 clocks.
- R6: While `mode_fast`=1, `ser_out[15:8]` is held at 0.
- R7: The active code of a stream changes only at a clock edge where `frame_pulse` is 1. At that edge it takes the stored code. Until then, output timing follows the previous active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_fast | input | 1 | 1 selects the fast-rate code mapping |
| frame_pulse | input | 1 | Frame boundary marker; loads stored codes into the active set |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Stream register index |
| reg_wdata | input | 16 | Write data; bits 1:0 hold the code |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ser_in | input | 16 | Early serial input, one bit per stream |
| ser_out | output | 16 | Aligned serial output, one bit per stream |

## Verification
The hardest case to reach from the ports is a stream whose stored code differs from its active code. The stored code can be read back, but the active code only shows up as output timing. To reach it, the bench writes a new code without a frame pulse and sends a single-cycle impulse through the stream. It then checks that the impulse still comes out at the old delay, and only afterwards issues the frame pulse and measures the new delay. The delay of every stream is measured as the first sample at which the impulse appears. This covers every code in both mappings.

// File: rtl/stream_advance_unit.sv
module stream_advance_unit #(
  parameter int STREAMS = 16,
  parameter int MAX_ADV = 6,
  parameter int REG_W   = 16,
  parameter int CODE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_fast,
  input  logic                       frame_pulse,
  input  logic                       reg_wr,
  input  logic [$clog2(STREAMS)-1:0] reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [STREAMS-1:0]         ser_in,
  output logic [STREAMS-1:0]         ser_out
);
  localparam int HALF = STREAMS / 2;
  localparam int SW   = $clog2(MAX_ADV + 1);

  logic [CODE_W-1:0] pend [STREAMS];
  logic [CODE_W-1:0] act  [STREAMS];
  logic [STREAMS*CODE_W-1:0] pend_flat, act_flat;
  logic unused_resv;

  assign unused_resv = ^reg_wdata[REG_W-1:CODE_W];
  assign reg_rdata = {{(REG_W-CODE_W){1'b0}}, pend[reg_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STREAMS; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
    end else begin
      if (reg_wr) pend[reg_addr] <= reg_wdata[CODE_W-1:0];
      if (frame_pulse)
        for (int i = 0; i < STREAMS; i++) act[i] <= pend[i];
    end
  end

  for (genvar g = 0; g < STREAMS; g++) begin : g_stream
    logic [MAX_ADV:1] line;
    logic [MAX_ADV:0] taps;
    logic [SW-1:0]    adv, idx;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) line <= '0;
      else        line <= {line[MAX_ADV-1:1], ser_in[g]};

    assign taps = {line, ser_in[g]};
    assign adv  = mode_fast ? SW'(act[g]) : SW'({act[g], 1'b0});
    assign idx  = SW'(MAX_ADV) - adv;

    if (g >= HALF) begin : g_upper
      assign ser_out[g] = mode_fast ? 1'b0 : taps[idx];
    end else begin : g_lower
      assign ser_out[g] = taps[idx];
    end

    assign pend_flat[g*CODE_W +: CODE_W] = pend[g];
    assign act_flat[g*CODE_W +: CODE_W]  = act[g];
  end
endmodule

// File: rtl/stream_advance_unit_chk.sv
module stream_advance_unit_chk #(
  parameter int STREAMS = 16,
  parameter int REG_W   = 16,
  parameter int CODE_W  = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mode_fast,
  input logic                        frame_pulse,
  input logic [REG_W-1:0]            reg_rdata,
  input logic [STREAMS-1:0]          ser_in,
  input logic [STREAMS-1:0]          ser_out,
  input logic [STREAMS*CODE_W-1:0]   pend_flat,
  input logic [STREAMS*CODE_W-1:0]   act_flat
);
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         warm <= '0;
    else if (warm != 6) warm <= warm + 3'd1;

  always_comb
    if (rst_n) assert_reserved_zero_R2: assert (reg_rdata[REG_W-1:CODE_W] == '0);

  assert_nominal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 6 && act_flat[CODE_W-1:0] == '0) |-> ser_out[0] == $past(ser_in[0], 6));

  assert_upper_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fast |-> ser_out[STREAMS-1:STREAMS/2] == '0);

  assert_hold_midframe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(act_flat));

  assert_load_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> act_flat == $past(pend_flat));
endmodule

bind stream_advance_unit stream_advance_unit_chk #(
  .STREAMS(STREAMS), .REG_W(REG_W), .CODE_W(CODE_W)
) chk (
  .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .frame_pulse(frame_pulse),
  .reg_rdata(reg_rdata), .ser_in(ser_in), .ser_out(ser_out),
  .pend_flat(pend_flat), .act_flat(act_flat)
);

// File: tb/stream_advance_unit_test.sv
module stream_advance_unit_test;
  logic clk = 0, rst_n = 0, mode_fast = 0, frame_pulse = 0, reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [15:0] ser_in = 0, ser_out;
  int checks = 0, fails = 0;
  int first_hi [16];
  bit done = 0;

  always #5 clk = ~clk;

  stream_advance_unit uut (
    .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .frame_pulse(frame_pulse),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_in(ser_in), .ser_out(ser_out)
  );

  // {mode[6], code[5:4], expected delay[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'h06, 8'h14, 8'h22, 8'h30, 8'h46, 8'h55, 8'h64, 8'h73
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_pulse = 1;
    @(negedge clk); frame_pulse = 0;
  endtask

  task automatic measure();
    for (int s = 0; s < 16; s++) first_hi[s] = 99;
    @(negedge clk); ser_in = '1;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) begin @(negedge clk); ser_in = '0; end
      #1;
      for (int s = 0; s < 16; s++)
        if (ser_out[s] && first_hi[s] == 99) first_hi[s] = k;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_addr = 4'd5; #1;
    chk(reg_rdata == 0, "R3 reset code", reg_rdata, 0);
    chk(ser_out == 0, "R3 reset output", ser_out, 0);

    wr(9, 16'hFFFE);
    wr(3, 16'h0001);
    reg_addr = 4'd9; #1;
    chk(reg_rdata == 16'h0002, "R1/R2 readback stream 9", reg_rdata, 2);
    reg_addr = 4'd3; #1;
    chk(reg_rdata == 16'h0001, "R1 readback stream 3", reg_rdata, 1);
    reg_addr = 4'd4; #1;
    chk(reg_rdata == 16'h0000, "R1 untouched stream 4", reg_rdata, 0);
    wr(7, 16'hABCF);
    reg_addr = 4'd7; #1;
    chk(reg_rdata == 16'h0003, "R2 reserved bits read 0", reg_rdata, 3);

    foreach (VEC[v]) begin
      mode_fast = VEC[v][6];
      for (int s = 0; s < 16; s++) wr(s, {14'd0, VEC[v][5:4]});
      frame();
      measure();
      for (int s = 0; s < 16; s++) begin
        int exp;
        exp = (mode_fast && s >= 8) ? 99 : int'(VEC[v][3:0]);
        chk(first_hi[s] == exp,
            mode_fast ? ((s >= 8) ? "R6 upper stream off" : "R5 fast delay")
                      : (VEC[v][5:4] == 0 ? "R3 nominal delay" : "R4 slow delay"),
            first_hi[s], exp);
      end
    end

    mode_fast = 0;
    for (int s = 0; s < 16; s++) wr(s, 16'h0000);
    frame();
    wr(0, 16'h0003);
    measure();
    chk(first_hi[0] == 6, "R7 held until frame", first_hi[0], 6);
    frame();
    measure();
    chk(first_hi[0] == 0, "R7 loaded at frame", first_hi[0], 0);
    chk(first_hi[1] == 6, "R7 other stream unchanged", first_hi[1], 6);

    mode_fast = 1;
    @(negedge clk); ser_in = '1; #1;
    chk(ser_out[15:8] == 0, "R6 upper forced low", ser_out[15:8], 0);
    ser_in = '0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule